// File: doc/BRIEF.md
# Transmit Character Slot Controller with Fill Insertion

This block decides, once per clock (one character slot), what the transmit path hands to the next stage: a host character, or a link-maintenance fill character. The host can feed characters in two ways, chosen by a mode pin. In direct mode, the block ignores the FIFO and captures the host bus whenever the host enables it and the host is not flagging full. In queued mode, the block pops characters from a first-word-fall-through transmit FIFO. In queued mode a halt input can stop the reads at once, without losing a character.

Every slot that receives no character carries a fill code, so the far end stays synchronised. The fill code depends on two pins. The first tells whether the downstream encoder is in use or bypassed: with the encoder in use the fill is an 8-bit command code, and with it bypassed the fill is a 10-bit pre-encoded pattern that goes straight to the shifter. The second is the byte-width select, which picks between two alternative fills. Each output character comes with a flag that marks it as fill (command) or data. The block has two register stages, an input register and a pipeline register, so a character reaches the output two clock edges after it is accepted.

Top module: `tx_fill_ctrl`

## Requirements
- R1: While rst_n is low, out_cmd is 1, out_char equals FILL_CMD_A zero-extended to 10 bits (default 10'h0B5), and fifo_rd is 0.
- R2: With fifo_bypass=1, a host_data word offered in a cycle where host_en=1 and host_full=0 appears on out_char after two rising clock edges with out_cmd=0. When enc_bypass=0, out_char[7:0]=host_data[7:0] and out_char[9:8]=0. When enc_bypass=1, all 10 bits pass through unchanged.
- R3: With fifo_bypass=1, a cycle in which host_en=0 or host_full=1 produces a fill character two edges later, with out_cmd=1.
- R4: The fill code is chosen from enc_bypass and wide_sel as they stand in the cycle before it is shown. enc_bypass=0 with wide_sel=1 gives FILL_CMD_A (0xB5), and with wide_sel=0 gives FILL_CMD_B (0x3C); both are zero-extended. enc_bypass=1 with wide_sel=1 gives FILL_PAT_A (10'h17C), and with wide_sel=0 gives FILL_PAT_B (10'h283).
- R5: With fifo_bypass=0, fifo_rd is 1 in a cycle exactly when fifo_empty=0 and halt=0. The fifo_data present in that cycle appears on out_char two edges later as data (out_cmd=0), formatted as in R2.
- R6: With fifo_bypass=0, a cycle in which fifo_empty=1 or halt=1 produces no read and yields a fill character two edges later. A halt therefore stops reads at the very next slot and keeps producing fill until it is released.
- R7: With fifo_bypass=1, halt, fifo_empty and fifo_data have no effect: fifo_rd stays 0 and the output follows R2 and R3.
- R8: With fifo_bypass=0, host_en, host_full and host_data have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock (reference clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_bypass | input | 1 | 1: direct host mode, 0: queued FIFO mode |
| enc_bypass | input | 1 | 1: downstream encoder bypassed (10-bit pre-encoded path) |
| wide_sel | input | 1 | Byte-width select; 0 picks the alternate fill |
| host_data | input | 10 | Host character bus |
| host_en | input | 1 | Host offers a character this slot |
| host_full | input | 1 | Host-side full flag; blocks capture |
| fifo_data | input | 10 | FIFO head character (first-word fall-through) |
| fifo_empty | input | 1 | FIFO has no character |
| halt | input | 1 | Stop FIFO reads (queued mode only) |
| fifo_rd | output | 1 | Pop strobe to the FIFO, one per slot at most |
| out_char | output | 10 | Character for this slot |
| out_cmd | output | 1 | 1: out_char is a fill command, 0: data |

## Verification
The hardest case to reach from the ports is the one where the mode pins change while a character is still in flight between the two register stages. In that case the fill code comes from the later mode setting, but the data/fill decision comes from the earlier one. The stimulus sweeps every combination of the three mode pins against every pattern of enable, full, empty and halt, and it switches mode with no idle gap, so these boundary slots come up often. The bench model tracks inputs from two slots back and mode pins from one slot back.

// File: rtl/tx_fill_pkg.sv
package tx_fill_pkg;
    parameter int TX_CODE_W = 10;
    parameter int TX_CMD_W  = 8;

    typedef struct packed {
        logic                 in_vld;
        logic [TX_CODE_W-1:0] in_data;
        logic [TX_CODE_W-1:0] out_char;
        logic                 out_cmd;
    } tx_state_t;
endpackage

// File: rtl/tx_fill_src_sel.sv
module tx_fill_src_sel
    import tx_fill_pkg::*;
(
    input  logic                 rst_n,
    input  logic                 fifo_bypass,
    input  logic [TX_CODE_W-1:0] host_data,
    input  logic                 host_en,
    input  logic                 host_full,
    input  logic [TX_CODE_W-1:0] fifo_data,
    input  logic                 fifo_empty,
    input  logic                 halt,
    output logic                 take,
    output logic [TX_CODE_W-1:0] take_data,
    output logic                 fifo_rd
);
    logic host_ok;
    logic fifo_ok;

    always_comb begin
        host_ok   = host_en && !host_full;
        // Halt goes straight to the read gate: the current slot is already stopped
        fifo_ok   = !fifo_empty && !halt && rst_n;
        fifo_rd   = !fifo_bypass && fifo_ok;
        take      = fifo_bypass ? host_ok : fifo_ok;
        take_data = fifo_bypass ? host_data : fifo_data;
    end
endmodule

// File: rtl/tx_fill_fmt.sv
module tx_fill_fmt
    import tx_fill_pkg::*;
#(
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_A = 8'hB5,
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_B = 8'h3C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_A = 10'h17C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_B = 10'h283
) (
    input  logic                 vld,
    input  logic [TX_CODE_W-1:0] data,
    input  logic                 enc_bypass,
    input  logic                 wide_sel,
    output logic [TX_CODE_W-1:0] char_o,
    output logic                 cmd_o
);
    localparam int PAD_W = TX_CODE_W - TX_CMD_W;

    logic [TX_CODE_W-1:0] fill_code;
    logic [TX_CODE_W-1:0] data_fmt;

    always_comb begin
        if (enc_bypass) begin
            fill_code = wide_sel ? FILL_PAT_A : FILL_PAT_B;
            data_fmt  = data;
        end else begin
            fill_code = {{PAD_W{1'b0}}, (wide_sel ? FILL_CMD_A : FILL_CMD_B)};
            data_fmt  = {{PAD_W{1'b0}}, data[TX_CMD_W-1:0]};
        end
        char_o = vld ? data_fmt : fill_code;
        cmd_o  = !vld;
    end
endmodule

// File: rtl/tx_fill_ctrl.sv
module tx_fill_ctrl
    import tx_fill_pkg::*;
#(
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_A = 8'hB5,
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_B = 8'h3C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_A = 10'h17C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_B = 10'h283
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_bypass,
    input  logic                 enc_bypass,
    input  logic                 wide_sel,
    input  logic [TX_CODE_W-1:0] host_data,
    input  logic                 host_en,
    input  logic                 host_full,
    input  logic [TX_CODE_W-1:0] fifo_data,
    input  logic                 fifo_empty,
    input  logic                 halt,
    output logic                 fifo_rd,
    output logic [TX_CODE_W-1:0] out_char,
    output logic                 out_cmd
);
    localparam int PAD_W = TX_CODE_W - TX_CMD_W;

    tx_state_t            st_d, st_q;
    logic                 take;
    logic [TX_CODE_W-1:0] take_data;
    logic [TX_CODE_W-1:0] fmt_char;
    logic                 fmt_cmd;

    tx_fill_src_sel u_src (
        .rst_n      (rst_n),
        .fifo_bypass(fifo_bypass),
        .host_data  (host_data),
        .host_en    (host_en),
        .host_full  (host_full),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .halt       (halt),
        .take       (take),
        .take_data  (take_data),
        .fifo_rd    (fifo_rd)
    );

    tx_fill_fmt #(
        .FILL_CMD_A(FILL_CMD_A),
        .FILL_CMD_B(FILL_CMD_B),
        .FILL_PAT_A(FILL_PAT_A),
        .FILL_PAT_B(FILL_PAT_B)
    ) u_fmt (
        .vld       (st_q.in_vld),
        .data      (st_q.in_data),
        .enc_bypass(enc_bypass),
        .wide_sel  (wide_sel),
        .char_o    (fmt_char),
        .cmd_o     (fmt_cmd)
    );

    always_comb begin
        st_d          = st_q;
        st_d.in_vld   = take;
        st_d.in_data  = take ? take_data : st_q.in_data;
        st_d.out_char = fmt_char;
        st_d.out_cmd  = fmt_cmd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.in_vld   <= 1'b0;
            st_q.in_data  <= '0;
            st_q.out_char <= {{PAD_W{1'b0}}, FILL_CMD_A};
            st_q.out_cmd  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_char = st_q.out_char;
    assign out_cmd  = st_q.out_cmd;
endmodule

// File: rtl/tx_fill_ctrl_chk.sv
module tx_fill_ctrl_chk
    import tx_fill_pkg::*;
#(
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_A = 8'hB5,
    parameter logic [TX_CMD_W-1:0]  FILL_CMD_B = 8'h3C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_A = 10'h17C,
    parameter logic [TX_CODE_W-1:0] FILL_PAT_B = 10'h283
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fifo_bypass,
    input logic                 host_en,
    input logic                 host_full,
    input logic                 fifo_empty,
    input logic                 halt,
    input logic                 fifo_rd,
    input logic [TX_CODE_W-1:0] out_char,
    input logic                 out_cmd
);
    localparam int PAD_W = TX_CODE_W - TX_CMD_W;

    // R5
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_empty && !halt));

    // R7
    no_rd_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_bypass |-> !fifo_rd);

    // R5
    rd_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> ##2 !out_cmd);

    // R6
    starve_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_bypass && (fifo_empty || halt)) |-> ##2 out_cmd);

    // R3
    host_idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_bypass && !(host_en && !host_full)) |-> ##2 out_cmd);

    // R2
    host_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_bypass && host_en && !host_full) |-> ##2 !out_cmd);

    // R4
    fill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cmd |-> (out_char == {{PAD_W{1'b0}}, FILL_CMD_A} ||
                     out_char == {{PAD_W{1'b0}}, FILL_CMD_B} ||
                     out_char == FILL_PAT_A || out_char == FILL_PAT_B));
endmodule

bind tx_fill_ctrl tx_fill_ctrl_chk #(
    .FILL_CMD_A(FILL_CMD_A),
    .FILL_CMD_B(FILL_CMD_B),
    .FILL_PAT_A(FILL_PAT_A),
    .FILL_PAT_B(FILL_PAT_B)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_bypass(fifo_bypass),
    .host_en    (host_en),
    .host_full  (host_full),
    .fifo_empty (fifo_empty),
    .halt       (halt),
    .fifo_rd    (fifo_rd),
    .out_char   (out_char),
    .out_cmd    (out_cmd)
);

// File: tb/sim_tx_fill_ctrl.sv
module sim_tx_fill_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_bypass, enc_bypass, wide_sel;
    logic [9:0] host_data, fifo_data;
    logic       host_en, host_full, fifo_empty, halt;
    logic       fifo_rd;
    logic [9:0] out_char;
    logic       out_cmd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tx_fill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fifo_bypass(fifo_bypass), .enc_bypass(enc_bypass),
        .wide_sel(wide_sel), .host_data(host_data), .host_en(host_en), .host_full(host_full),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .halt(halt), .fifo_rd(fifo_rd),
        .out_char(out_char), .out_cmd(out_cmd)
    );

    task automatic chk(input bit ok, input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] fill_of(input bit eb, input bit ws);
        if (eb) return ws ? 10'h17C : 10'h283;
        return ws ? 10'h0B5 : 10'h03C;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Model pipeline: p1 = inputs driven one slot ago, p2 = two slots ago
    bit       p1_v, p2_v, p1_fb, p2_fb, p1_eb, p1_ws;
    logic [9:0] p1_d, p2_d;
    int       step = 0;

    initial begin
        rst_n = 0; fifo_bypass = 0; enc_bypass = 0; wide_sel = 1;
        host_data = '0; fifo_data = 10'h155; host_en = 1; host_full = 0;
        fifo_empty = 0; halt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, with the FIFO offering a character
        chk(out_cmd == 1'b1, "R1 cmd", {10'b0, out_cmd}, 11'd1);
        chk(out_char == 10'h0B5, "R1 char", {1'b0, out_char}, 11'h0B5);
        chk(fifo_rd == 1'b0, "R1 rd", {10'b0, fifo_rd}, 11'd0);
        fifo_empty = 1;
        rst_n = 1;
        p1_v = 0; p2_v = 0; p1_fb = 0; p2_fb = 0; p1_eb = 0; p1_ws = 1; p1_d = '0; p2_d = '0;

        for (int m = 0; m < 8; m++) begin
            for (int pat = 0; pat < 16; pat++) begin
                for (int rep = 0; rep < 3; rep++) begin
                    @(negedge clk);
                    if (step >= 2) begin
                        logic [9:0] exp_c;
                        bit         exp_m;
                        string      rq;
                        exp_m = !p2_v;
                        if (p2_v) exp_c = p1_eb ? p2_d : {2'b00, p2_d[7:0]};
                        else      exp_c = fill_of(p1_eb, p1_ws);
                        if (p2_v)       rq = p2_fb ? "R2 host data" : "R5 fifo data";
                        else            rq = p2_fb ? "R3/R4 host idle fill" : "R6/R4 starve fill";
                        chk(out_char == exp_c && out_cmd == exp_m, rq,
                            {out_cmd, out_char}, {exp_m, exp_c});
                    end
                    fifo_bypass = m[0];
                    enc_bypass  = m[1];
                    wide_sel    = m[2];
                    host_en     = pat[0];
                    host_full   = pat[1];
                    fifo_empty  = pat[2];
                    halt        = pat[3];
                    host_data   = 10'((m * 97 + pat * 13 + rep * 331) % 1024);
                    fifo_data   = host_data ^ 10'h2A5;
                    #1;
                    begin
                        bit exp_rd;
                        exp_rd = !fifo_bypass && !fifo_empty && !halt;
                        // R5 read gating; R7 no read in direct mode
                        chk(fifo_rd == exp_rd, fifo_bypass ? "R7 rd ignored" : "R5 rd gate",
                            {10'b0, fifo_rd}, {10'b0, exp_rd});
                    end
                    // R8: host pins are irrelevant in queued mode (model uses FIFO only)
                    p2_v  = p1_v;  p2_d = p1_d;  p2_fb = p1_fb;
                    p1_fb = fifo_bypass;
                    p1_v  = fifo_bypass ? (host_en && !host_full) : (!fifo_empty && !halt);
                    p1_d  = fifo_bypass ? host_data : fifo_data;
                    p1_eb = enc_bypass;
                    p1_ws = wide_sel;
                    step++;
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule